// File: doc/BRIEF.md
# Card Command Response Capture Unit

This unit starts one card command at a time and collects the card's answer. Software or a surrounding controller writes an 11-bit command word and a 32-bit argument. When that word has its enable bit set and its pending bit clear, the unit presents the command index and argument to the card-side engine for one cycle and goes busy. It then gathers the reply bytes into a staging buffer. When the card reports the end of the reply and its length, the unit judges the outcome and produces a one-cycle status pulse: response received, command sent, or command timeout.

A reply is accepted only if its length suits the request. A short reply is four bytes and a long reply is sixteen. When the reply is accepted, the staged bytes are copied into four 32-bit response words, each packed most-significant byte first. Any mismatch, and any card error raised while the command is running, ends the command as a timeout and leaves the response words unchanged. The enable bit in the readable command word clears itself when the command finishes.

Top module: `cmd_resp_unit`

## Requirements
- R1: The command word layout is: bits 5:0 index, bit 6 reply wanted, bit 7 long reply, bit 8 interrupt mode (stored only), bit 9 pending, bit 10 enable. A write with enable=1 and pending=0 while idle produces, on the next cycle, a one-cycle `card_cmd_valid` pulse carrying the index and argument, and sets `busy`.
- R2: While a command runs, `cmd_rdata` reads back the written word with bit 10 set. In the cycle the completion pulse appears, bit 10 reads 0, `busy` is low and the other bits are kept.
- R3: A write with enable=1 and pending=1 issues nothing and raises no status pulse. It stores the word with bit 10 cleared.
- R4: Command writes made while `busy` is high are ignored: the readback does not change and no second issue pulse appears.
- R5: Reply bytes are packed big-endian. Byte 4k+j goes to word k, bits (31-8j):(24-8j). Bytes after the sixteenth are dropped.
- R6: When a reply is wanted, a length of 4 with bit 7 clear is accepted as short: word 0 takes the bytes and words 1-3 become zero. A length of 16 is accepted in long form even when bit 7 is clear. Acceptance pulses `evt_flags` bit 6.
- R7: On a long reply, bit 0 of word 3 is forced to zero.
- R8: When a reply is wanted, a length of 0, any length other than 4 or 16, or a length of 4 when bit 7 is set pulses `evt_flags` bit 2, and the response words keep their old values.
- R9: When no reply is wanted, the end of the reply pulses `evt_flags` bit 7, whatever the length.
- R10: `card_err` while busy ends the command with `evt_flags` bit 2. It takes priority over a reply end in the same cycle.
- R11: Status pulses last exactly one cycle, at most one bit is set at a time, and they appear in the cycle after the ending input is sampled. Bytes, ends and errors while idle have no effect.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 11 | Command word to write |
| cmd_arg | input | 32 | Command argument, sampled with an accepted write |
| cmd_rdata | output | 11 | Stored command word with self-clearing enable |
| busy | output | 1 | A command is in progress |
| card_cmd_valid | output | 1 | One-cycle command issue pulse |
| card_cmd_index | output | 6 | Index of the issued command |
| card_cmd_arg | output | 32 | Argument of the issued command |
| card_byte_valid | input | 1 | Reply byte present |
| card_byte | input | 8 | Reply byte |
| card_resp_end | input | 1 | Reply finished |
| card_resp_len | input | 5 | Reply length in bytes, valid with card_resp_end |
| card_err | input | 1 | Card reports failure |
| resp_words | output | 128 | Response words, word k at bits 32k+31:32k |
| evt_flags | output | 8 | Status pulses: bit 2 timeout, bit 6 reply accepted, bit 7 command sent |

## Verification
An accepted command write shows up one cycle later as the issue pulse, the busy level and the enable readback. A reply end or card error shows up one cycle after it is sampled as the status pulse, the new response words, busy low and the enable bit cleared, and the pulse is gone one cycle after that. The bench drives every input one nanosecond after a rising edge and reads the outputs at that same point after the following edge, so each expected value is compared in exactly the cycle in which it becomes due. Seeded random commands, with random lengths, byte counts and error points, are mixed with directed cases for every length rule, the pending bit, writes made while busy, and traffic while idle.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
  localparam int CMD_W     = 11;
  localparam int IDX_W     = 6;
  localparam int CB_RESP   = 6;
  localparam int CB_LONG   = 7;
  localparam int CB_INTR   = 8;
  localparam int CB_PEND   = 9;
  localparam int CB_EN     = 10;

  localparam int FLAG_W    = 8;
  localparam int FB_TMO    = 2;
  localparam int FB_RESP   = 6;
  localparam int FB_SENT   = 7;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_SENT = 2'd1,
    OUT_RESP = 2'd2,
    OUT_TMO  = 2'd3
  } outcome_t;
endpackage

// File: rtl/cmdrsp_ctrl.sv
module cmdrsp_ctrl
  import cmdrsp_pkg::*;
#(
  parameter int ARG_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_wdata,
  input  logic [ARG_W-1:0]   arg_in,
  input  logic               done,
  output logic               accept,
  output logic [CMD_W-1:0]   cmd_q,
  output logic               busy_q,
  output logic               issue_q,
  output logic [IDX_W-1:0]   issue_idx_q,
  output logic [ARG_W-1:0]   issue_arg_q,
  output logic               exp_resp_q,
  output logic               exp_long_q
);
  localparam logic [CMD_W-1:0] EN_MASK = CMD_W'(1) << CB_EN;

  logic wr_idle;
  assign wr_idle = cmd_wr && !busy_q;
  assign accept  = wr_idle && cmd_wdata[CB_EN] && !cmd_wdata[CB_PEND];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q       <= '0;
      busy_q      <= 1'b0;
      issue_q     <= 1'b0;
      issue_idx_q <= '0;
      issue_arg_q <= '0;
      exp_resp_q  <= 1'b0;
      exp_long_q  <= 1'b0;
    end else begin
      issue_q <= 1'b0;
      if (busy_q) begin
        if (done) begin
          busy_q <= 1'b0;
          cmd_q  <= cmd_q & ~EN_MASK;
        end
      end else if (accept) begin
        cmd_q       <= cmd_wdata;
        busy_q      <= 1'b1;
        issue_q     <= 1'b1;
        issue_idx_q <= cmd_wdata[IDX_W-1:0];
        issue_arg_q <= arg_in;
        exp_resp_q  <= cmd_wdata[CB_RESP];
        exp_long_q  <= cmd_wdata[CB_LONG];
      end else if (wr_idle) begin
        cmd_q <= cmd_wdata & ~EN_MASK;
      end
    end
  end

  assert_issue_after_write_R1: assert property (@(posedge clk) disable iff (rst)
    issue_q |-> ($past(cmd_wr) && !$past(busy_q)));
  assert_issue_single_R1: assert property (@(posedge clk) disable iff (rst)
    issue_q |=> !issue_q);
  assert_en_while_busy_R2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> cmd_q[CB_EN]);
  assert_en_cleared_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> !cmd_q[CB_EN]);
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done) |=> ($stable(cmd_q) && busy_q));
endmodule

// File: rtl/cmdrsp_bytecap.sv
module cmdrsp_bytecap #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32,
  parameter int NWORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          cap_en,
  input  logic                          byte_valid,
  input  logic [BYTE_W-1:0]             byte_in,
  output logic [NWORDS-1:0][WORD_W-1:0] stage_q
);
  localparam int BPW    = WORD_W / BYTE_W;
  localparam int NBYTES = NWORDS * BPW;
  localparam int CNT_W  = $clog2(NBYTES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign take = cap_en && byte_valid && (cnt_q < CNT_W'(NBYTES));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q   <= '0;
      stage_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      for (int w = 0; w < NWORDS; w++) begin
        for (int l = 0; l < BPW; l++) begin
          if (cnt_q == CNT_W'(w * BPW + l))
            stage_q[w][(BPW-1-l)*BYTE_W +: BYTE_W] <= byte_in;
        end
      end
    end
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(NBYTES));
  assert_idle_no_capture_R11: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/cmdrsp_judge.sv
module cmdrsp_judge
  import cmdrsp_pkg::*;
#(
  parameter int LEN_W     = 5,
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 16
) (
  input  logic             busy,
  input  logic             resp_end,
  input  logic [LEN_W-1:0] resp_len,
  input  logic             card_err,
  input  logic             exp_resp,
  input  logic             exp_long,
  output logic             done,
  output outcome_t         outcome,
  output logic             fmt_long
);
  logic is_short, is_long;
  assign is_short = (resp_len == LEN_W'(SHORT_LEN));
  assign is_long  = (resp_len == LEN_W'(LONG_LEN));
  assign done     = busy && (card_err || resp_end);

  always_comb begin
    outcome  = OUT_NONE;
    fmt_long = 1'b0;
    if (done) begin
      if (card_err)                    outcome = OUT_TMO;
      else if (!exp_resp)              outcome = OUT_SENT;
      else if (is_long) begin
        outcome  = OUT_RESP;
        fmt_long = 1'b1;
      end
      else if (is_short && !exp_long)  outcome = OUT_RESP;
      else                             outcome = OUT_TMO;
    end
  end
endmodule

// File: rtl/cmdrsp_commit.sv
module cmdrsp_commit
  import cmdrsp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          done,
  input  outcome_t                      outcome,
  input  logic                          fmt_long,
  input  logic [NWORDS-1:0][WORD_W-1:0] stage,
  output logic [NWORDS-1:0][WORD_W-1:0] resp_q,
  output logic [FLAG_W-1:0]             flags_q
);
  logic last_long_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q      <= '0;
      flags_q     <= '0;
      last_long_q <= 1'b0;
    end else begin
      flags_q <= '0;
      if (done) begin
        unique case (outcome)
          OUT_RESP: begin
            flags_q[FB_RESP] <= 1'b1;
            last_long_q      <= fmt_long;
            for (int w = 0; w < NWORDS; w++) begin
              if (fmt_long)
                resp_q[w] <= (w == NWORDS - 1) ? (stage[w] & ~WORD_W'(1)) : stage[w];
              else
                resp_q[w] <= (w == 0) ? stage[0] : '0;
            end
          end
          OUT_SENT: flags_q[FB_SENT] <= 1'b1;
          OUT_TMO:  flags_q[FB_TMO]  <= 1'b1;
          default:  flags_q <= '0;
        endcase
      end
    end
  end

  assert_one_flag_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flags_q));
  assert_flag_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (flags_q != '0) |=> (flags_q == '0));
  assert_tmo_keeps_words_R8: assert property (@(posedge clk) disable iff (rst)
    flags_q[FB_TMO] |-> (resp_q == $past(resp_q)));
  assert_sent_keeps_words_R9: assert property (@(posedge clk) disable iff (rst)
    flags_q[FB_SENT] |-> (resp_q == $past(resp_q)));
  assert_long_lsb_R7: assert property (@(posedge clk) disable iff (rst)
    (flags_q[FB_RESP] && last_long_q) |-> !resp_q[NWORDS-1][0]);
  assert_short_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (flags_q[FB_RESP] && !last_long_q) |-> (resp_q[NWORDS-1:1] == '0));
endmodule

// File: rtl/cmd_resp_unit.sv
module cmd_resp_unit
  import cmdrsp_pkg::*;
#(
  parameter int ARG_W  = 32,
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_wr,
  input  logic [CMD_W-1:0]         cmd_wdata,
  input  logic [ARG_W-1:0]         cmd_arg,
  output logic [CMD_W-1:0]         cmd_rdata,
  output logic                     busy,
  output logic                     card_cmd_valid,
  output logic [IDX_W-1:0]         card_cmd_index,
  output logic [ARG_W-1:0]         card_cmd_arg,
  input  logic                     card_byte_valid,
  input  logic [BYTE_W-1:0]        card_byte,
  input  logic                     card_resp_end,
  input  logic [LEN_W-1:0]         card_resp_len,
  input  logic                     card_err,
  output logic [NWORDS*WORD_W-1:0] resp_words,
  output logic [FLAG_W-1:0]        evt_flags
);
  localparam int BPW       = WORD_W / BYTE_W;
  localparam int SHORT_LEN = BPW;
  localparam int LONG_LEN  = NWORDS * BPW;

  logic                          accept, done, fmt_long, exp_resp, exp_long;
  outcome_t                      outcome;
  logic [NWORDS-1:0][WORD_W-1:0] stage, resp_q;

  cmdrsp_ctrl #(.ARG_W(ARG_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .arg_in(cmd_arg),
    .done(done), .accept(accept), .cmd_q(cmd_rdata), .busy_q(busy),
    .issue_q(card_cmd_valid), .issue_idx_q(card_cmd_index), .issue_arg_q(card_cmd_arg),
    .exp_resp_q(exp_resp), .exp_long_q(exp_long)
  );

  cmdrsp_bytecap #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .NWORDS(NWORDS)) u_cap (
    .clk(clk), .rst(rst), .clear(accept), .cap_en(busy),
    .byte_valid(card_byte_valid), .byte_in(card_byte), .stage_q(stage)
  );

  cmdrsp_judge #(.LEN_W(LEN_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_judge (
    .busy(busy), .resp_end(card_resp_end), .resp_len(card_resp_len), .card_err(card_err),
    .exp_resp(exp_resp), .exp_long(exp_long), .done(done), .outcome(outcome),
    .fmt_long(fmt_long)
  );

  cmdrsp_commit #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_commit (
    .clk(clk), .rst(rst), .done(done), .outcome(outcome), .fmt_long(fmt_long),
    .stage(stage), .resp_q(resp_q), .flags_q(evt_flags)
  );

  assign resp_words = resp_q;

  assert_flag_needs_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (evt_flags != '0) |-> ($past(busy) && !busy));
  assert_err_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && card_err) |=> evt_flags[FB_TMO]);
  assert_no_issue_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> !card_cmd_valid);
endmodule

// File: tb/tb_cmd_resp_unit.sv
module tb_cmd_resp_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         cmd_wr;
  logic [10:0]  cmd_wdata;
  logic [31:0]  cmd_arg;
  logic [10:0]  cmd_rdata;
  logic         busy, card_cmd_valid;
  logic [5:0]   card_cmd_index;
  logic [31:0]  card_cmd_arg;
  logic         card_byte_valid;
  logic [7:0]   card_byte;
  logic         card_resp_end;
  logic [4:0]   card_resp_len;
  logic         card_err;
  logic [127:0] resp_words;
  logic [7:0]   evt_flags;

  cmd_resp_unit dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_arg(cmd_arg),
    .cmd_rdata(cmd_rdata), .busy(busy), .card_cmd_valid(card_cmd_valid),
    .card_cmd_index(card_cmd_index), .card_cmd_arg(card_cmd_arg),
    .card_byte_valid(card_byte_valid), .card_byte(card_byte),
    .card_resp_end(card_resp_end), .card_resp_len(card_resp_len), .card_err(card_err),
    .resp_words(resp_words), .evt_flags(evt_flags)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  logic [7:0]   bb [24];
  logic [127:0] exp_w = '0;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [127:0] staged(input int n);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++)
      if (i < n) r[(i/4)*32 + (3-(i%4))*8 +: 8] = bb[i];
    return r;
  endfunction

  // err_at: -1 none; 0..nbytes-1 error instead of that byte; nbytes error with the end
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                         input bit rsp, input bit lng, input bit intr,
                         input int nbytes, input int len, input int err_at,
                         input bit poke_busy);
    logic [10:0]  word;
    logic [7:0]   eflag;
    logic [127:0] stg;
    bit           erred = 1'b0;
    int           got   = 0;
    word = {1'b1, 1'b0, intr, lng, rsp, idx};
    for (int i = 0; i < nbytes && i < 24; i++) bb[i] = 8'($urandom);
    cmd_wr = 1'b1; cmd_wdata = word; cmd_arg = arg;
    tick();
    cmd_wr = 1'b0;
    chk("R1 issue valid", card_cmd_valid, 1'b1);
    chk("R1 issue index", card_cmd_index, idx);
    chk("R1 issue arg", card_cmd_arg, arg);
    chk("R1 busy", busy, 1'b1);
    chk("R2 enable readback", cmd_rdata, word);
    if (poke_busy) begin
      cmd_wr = 1'b1; cmd_wdata = ~word | 11'h400; cmd_arg = ~arg;
      tick();
      cmd_wr = 1'b0;
      chk("R4 no reissue", card_cmd_valid, 1'b0);
      chk("R4 readback kept", cmd_rdata, word);
      chk("R4 still busy", busy, 1'b1);
    end
    for (int i = 0; i < nbytes; i++) begin
      if (err_at == i) begin
        card_err = 1'b1;
        tick();
        card_err = 1'b0;
        erred = 1'b1;
        break;
      end
      card_byte_valid = 1'b1; card_byte = bb[i];
      tick();
      card_byte_valid = 1'b0;
      got++;
      if (i == 0) chk("R1 issue one cycle", card_cmd_valid, 1'b0);
    end
    if (!erred) begin
      card_resp_end = 1'b1; card_resp_len = 5'(len);
      card_err = (err_at == nbytes);
      tick();
      card_resp_end = 1'b0; card_err = 1'b0;
    end
    stg = staged(got);
    if (erred || err_at == nbytes) eflag = 8'h04;
    else if (!rsp) eflag = 8'h80;
    else if (len == 16) begin
      eflag = 8'h40;
      exp_w = stg;
      exp_w[96] = 1'b0;
    end else if (len == 4 && !lng) begin
      eflag = 8'h40;
      exp_w = {96'h0, stg[31:0]};
    end else eflag = 8'h04;
    if (eflag == 8'h04) chk(erred || err_at == nbytes ? "R10 error timeout" : "R8 timeout", evt_flags, eflag);
    else if (eflag == 8'h80) chk("R9 sent", evt_flags, eflag);
    else chk(len == 16 ? "R7 long accept" : "R6 short accept", evt_flags, eflag);
    chk("R5 R6 R7 R8 response words", resp_words, exp_w);
    chk("R2 enable cleared", cmd_rdata, word & 11'h3ff);
    chk("R2 busy low", busy, 1'b0);
    tick();
    chk("R11 pulse ends", evt_flags, 8'h00);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmd_wr = 0; cmd_wdata = 0; cmd_arg = 0; card_byte_valid = 0;
    card_byte = 0; card_resp_end = 0; card_resp_len = 0; card_err = 0;
    void'($urandom(32'h5eed_0042));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R12 reset busy", busy, 1'b0);
    chk("R12 reset flags", evt_flags, 8'h00);
    chk("R12 reset readback", cmd_rdata, 11'h000);
    chk("R12 reset words", resp_words, 128'h0);
    chk("R12 reset issue", card_cmd_valid, 1'b0);

    run_cmd(6'd17, 32'hCAFE_0001, 1, 0, 0, 4, 4, -1, 0);   // R6 short
    run_cmd(6'd2, 32'h0, 1, 1, 0, 16, 16, -1, 0);          // R7 long
    bb[15] = 8'hFF;
    run_cmd(6'd9, 32'h1234, 1, 1, 1, 4, 4, -1, 0);         // R8 short reply to long
    run_cmd(6'd8, 32'h5, 1, 0, 0, 0, 0, -1, 0);            // R8 length zero
    run_cmd(6'd8, 32'h6, 1, 0, 0, 7, 7, -1, 0);            // R8 odd length
    run_cmd(6'd10, 32'h7, 1, 0, 0, 16, 16, -1, 0);         // R6 long form without bit 7
    run_cmd(6'd0, 32'h8, 0, 0, 0, 0, 0, -1, 0);            // R9
    run_cmd(6'd7, 32'h9, 0, 1, 0, 16, 16, -1, 0);          // R9
    run_cmd(6'd3, 32'hA, 1, 0, 0, 4, 4, 2, 0);             // R10 mid error
    run_cmd(6'd3, 32'hB, 1, 0, 0, 4, 4, 4, 0);             // R10 error with end
    run_cmd(6'd55, 32'hC, 1, 1, 0, 20, 16, -1, 0);         // R5 extra bytes dropped
    run_cmd(6'd41, 32'hD, 1, 0, 0, 4, 4, -1, 1);           // R4 write while busy

    // R3 pending
    cmd_wr = 1'b1; cmd_wdata = 11'b110_1100_0101; cmd_arg = 32'hEE;
    tick();
    cmd_wr = 1'b0;
    chk("R3 no issue", card_cmd_valid, 1'b0);
    chk("R3 not busy", busy, 1'b0);
    chk("R3 enable cleared", cmd_rdata, 11'b010_1100_0101);
    tick();
    chk("R3 no flag", evt_flags, 8'h00);

    // R11 idle traffic ignored
    card_byte_valid = 1'b1; card_byte = 8'h5A; card_resp_end = 1'b1;
    card_resp_len = 5'd4; card_err = 1'b1;
    tick();
    card_byte_valid = 1'b0; card_resp_end = 1'b0; card_err = 1'b0;
    chk("R11 idle no flag", evt_flags, 8'h00);
    tick();
    chk("R11 idle no flag later", evt_flags, 8'h00);
    chk("R11 idle words kept", resp_words, exp_w);
    run_cmd(6'd12, 32'hF, 1, 0, 0, 4, 4, -1, 0);

    for (int k = 0; k < 60; k++) begin
      int sel, nb, ln, ea;
      sel = int'($urandom % 4);
      ln  = (sel == 0) ? 4 : (sel == 1) ? 16 : (sel == 2) ? 0 : int'($urandom % 32);
      nb  = ($urandom % 4 == 0) ? int'($urandom % 21) : ((ln > 20) ? 20 : ln);
      ea  = ($urandom % 5 == 0) ? int'($urandom % (nb + 1)) : -1;
      run_cmd(6'($urandom), $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
              nb, ln, ea, ($urandom % 6 == 0));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule